// File: doc/BRIEF.md
# Operand Access Address Update Unit

This block turns an already decoded operand location into the address of one access, and it works out what a register-based mode does to its base register. A request carries a set of mode flags, a register number and that register's current value, a displacement, the instruction address, an operand length code and a load/store bit. One clock later the block presents the access address, the byte lane that a narrow register or literal operand occupies, an illegal flag, and, when the mode changes the register, a one-cycle write-back of the updated register value.

Operands wider than one bus access are moved as a series of requests. The block keeps a running byte offset between them: memory modes that do not touch the register advance it by the operand length after each access, and predecrement and postincrement clear it. A request that starts a new operand clears the offset before it is used. The data transfer itself happens elsewhere.

Flag bits of `req_flags`: bit 0 register direct, bit 1 immediate literal, bit 2 absolute address, bit 3 relative to instruction address, bit 4 postincrement, bit 5 predecrement, bit 6 add displacement. Direct takes precedence over immediate, immediate over absolute; with none of the three set the access is register indirect.

Top module: `oau_access_unit`

## Requirements
- R1: `req_len_code` values 0, 1, 2, 3 and 4 select operand lengths of 1, 2, 4, 8 and 12 bytes; codes 5 to 7 make the access illegal.
- R2: The register step equals the operand length, except that a 1-byte operand on register 15 steps the register by 2.
- R3: Predecrement forms the address from the register value minus the step (plus the displacement when bit 6 is set), writes that decremented value back and leaves the running offset at zero.
- R4: Postincrement forms the address from the register value plus the running offset (plus the displacement when bit 6 is set), writes back the register value plus the step and leaves the running offset at zero.
- R5: Any other legal access adds the operand length to the running offset; a request with `req_new_op` high uses an offset of zero.
- R6: Indirect addresses are base plus optional displacement plus running offset, where the base is the register value, or the instruction address plus 4 when bit 3 is set; an absolute access uses the displacement plus the running offset; direct and immediate accesses report address zero.
- R7: A store whose flags include immediate (bit 1) or instruction-relative (bit 3) is illegal.
- R8: Postincrement together with instruction-relative addressing, and postincrement together with predecrement, are illegal.
- R9: A register-direct access is illegal when the operand is longer than 4 bytes or the running offset in use is not zero.
- R10: For direct and immediate accesses, a 1-byte operand sits in lane 3 and a 2-byte operand in lane 2 of the 32-bit word (lane 0 being the most significant byte); all other legal accesses report lane 0.
- R11: Results appear one cycle after `req_valid`, with `acc_valid` high for exactly that cycle; `wb_en` is raised only in that same cycle, only for a legal predecrement or postincrement that is not instruction-relative.
- R12: An illegal access neither writes back a register nor advances the running offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One access requested this cycle |
| req_new_op | input | 1 | Access is the first part of a new operand |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_flags | input | 7 | Mode flags, bit meanings above |
| req_reg_num | input | 4 | Base or direct register number |
| req_len_code | input | 3 | Operand length code |
| req_reg_val | input | 32 | Current value of the register |
| req_disp | input | 32 | Displacement or absolute address |
| req_pc | input | 32 | Address of the instruction |
| acc_valid | output | 1 | Result valid |
| acc_illegal | output | 1 | Access is not permitted |
| acc_addr | output | 32 | Access address |
| acc_lane | output | 2 | Byte lane of a narrow register or literal operand |
| wb_en | output | 1 | Register write-back strobe |
| wb_reg | output | 4 | Register to write back |
| wb_val | output | 32 | Updated register value |

## Verification
On every cycle the assertions check the timing relation between a request and its result, that write-back never accompanies an illegal or absent result, that stores to literal or instruction-relative targets, wide direct operands and the forbidden flag pairs are always flagged, that a predecrement always changes the register, and that memory accesses report lane 0. The exact addresses, step sizes, the stack-pointer rule and the way the running offset evolves across a series of accesses depend on history and arithmetic, so only the bench's sweep over every flag combination, length code and load/store choice, with a reference model of the offset, can show them.

// File: rtl/oau_pkg.sv
// Shared definitions for the operand access address update unit.
// Assumes the flag vector layout documented in the brief.
package oau_pkg;
    localparam int FLAG_W       = 7;
    localparam int F_DIRECT     = 0;
    localparam int F_IMMED      = 1;
    localparam int F_ABS        = 2;
    localparam int F_PCREL      = 3;
    localparam int F_POSTINC    = 4;
    localparam int F_PREDEC     = 5;
    localparam int F_DISP       = 6;
    localparam int LEN_W        = 4;
endpackage

// File: rtl/oau_len_decode.sv
// Length decoder: maps the length code to a byte count and derives the
// register step, including the 2-byte step for byte operands on the
// stack pointer. Assumes codes above 4 are reserved.
module oau_len_decode
    import oau_pkg::*;
#(
    parameter int REG_NUM_W = 4,
    parameter int SP_REG    = 15
) (
    input  logic [2:0]           len_code,
    input  logic [REG_NUM_W-1:0] reg_num,
    output logic [LEN_W-1:0]     len_bytes,
    output logic [LEN_W-1:0]     step_bytes,
    output logic                 bad_len
);
    localparam logic [REG_NUM_W-1:0] SP_NUM = REG_NUM_W'(SP_REG);

    // Decode the length code into a byte count.
    always_comb begin
        bad_len = 1'b0;
        case (len_code)
            3'd0:    len_bytes = LEN_W'(1);
            3'd1:    len_bytes = LEN_W'(2);
            3'd2:    len_bytes = LEN_W'(4);
            3'd3:    len_bytes = LEN_W'(8);
            3'd4:    len_bytes = LEN_W'(12);
            default: begin
                len_bytes = '0;
                bad_len   = 1'b1;
            end
        endcase
    end

    // Keep the stack pointer word aligned for byte operands.
    always_comb begin
        if (len_bytes == LEN_W'(1) && reg_num == SP_NUM)
            step_bytes = LEN_W'(2);
        else
            step_bytes = len_bytes;
    end
endmodule

// File: rtl/oau_legality.sv
// Legality check: flags accesses the mode and direction cannot support.
// Assumes the running offset given is the one this access will use.
module oau_legality
    import oau_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic              is_store,
    input  logic [LEN_W-1:0]  len_bytes,
    input  logic              bad_len,
    input  logic [OFS_W-1:0]  ofs_use,
    output logic              illegal
);
    logic store_bad, pair_bad, direct_bad;

    // Collect each illegal condition separately, then combine.
    always_comb begin
        store_bad  = is_store && (flags[F_IMMED] || flags[F_PCREL]);
        pair_bad   = flags[F_POSTINC] && (flags[F_PCREL] || flags[F_PREDEC]);
        direct_bad = flags[F_DIRECT] &&
                     (len_bytes > LEN_W'(4) || ofs_use != '0);
        illegal    = bad_len || store_bad || pair_bad || direct_bad;
    end
endmodule

// File: rtl/oau_addr_calc.sv
// Address and register update calculator. Forms the access address for
// every mode, the byte lane of narrow register/literal operands, the
// write-back value and the running offset to keep if the access is legal.
// Assumes legality is judged elsewhere.
module oau_addr_calc
    import oau_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 8,
    parameter int PC_BIAS = 4
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] pc,
    input  logic [LEN_W-1:0]  len_bytes,
    input  logic [LEN_W-1:0]  step_bytes,
    input  logic [OFS_W-1:0]  ofs_use,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        lane,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_val,
    output logic [OFS_W-1:0]  ofs_next
);
    localparam logic [ADDR_W-1:0] PC_OFS = ADDR_W'(PC_BIAS);

    logic              is_reg_lit, is_abs, is_ind, steps_reg;
    logic [ADDR_W-1:0] step_w, ofs_w, disp_sel, reg_dec, reg_inc, base;

    // Classify the access and widen the small operands.
    always_comb begin
        is_reg_lit = flags[F_DIRECT] || flags[F_IMMED];
        is_abs     = !is_reg_lit && flags[F_ABS];
        is_ind     = !is_reg_lit && !flags[F_ABS];
        steps_reg  = flags[F_POSTINC] || flags[F_PREDEC];
        step_w     = ADDR_W'(step_bytes);
        ofs_w      = ADDR_W'(ofs_use);
        disp_sel   = flags[F_DISP] ? disp : '0;
        reg_dec    = reg_val - step_w;
        reg_inc    = reg_val + step_w;
    end

    // Pick the base of an indirect access.
    always_comb begin
        if (flags[F_PCREL])
            base = pc + PC_OFS;
        else if (flags[F_PREDEC])
            base = reg_dec;
        else
            base = reg_val;
    end

    // Form the access address; predecrement starts from a zero offset.
    always_comb begin
        if (is_reg_lit)
            addr = '0;
        else if (is_abs)
            addr = disp + ofs_w;
        else if (flags[F_PREDEC])
            addr = base + disp_sel;
        else
            addr = base + disp_sel + ofs_w;
    end

    // Narrow register or literal operands sit in the low-order lanes.
    always_comb begin
        lane = 2'd0;
        if (is_reg_lit) begin
            if (len_bytes == LEN_W'(1))
                lane = 2'd3;
            else if (len_bytes == LEN_W'(2))
                lane = 2'd2;
        end
    end

    // Register side effect and running offset for the next part.
    always_comb begin
        wb_req = is_ind && steps_reg && !flags[F_PCREL];
        wb_val = flags[F_PREDEC] ? reg_dec : reg_inc;
        if (is_ind && steps_reg)
            ofs_next = '0;
        else
            ofs_next = ofs_use + OFS_W'(len_bytes);
    end
endmodule

// File: rtl/oau_access_unit.sv
// Operand access address update unit (top). Registers one result per
// request and holds the running byte offset between the parts of a
// multi-part operand. Assumes at most one request per cycle.
module oau_access_unit
    import oau_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int REG_NUM_W = 4,
    parameter int OFS_W     = 8,
    parameter int SP_REG    = 15,
    parameter int PC_BIAS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_new_op,
    input  logic                 req_store,
    input  logic [6:0]           req_flags,
    input  logic [REG_NUM_W-1:0] req_reg_num,
    input  logic [2:0]           req_len_code,
    input  logic [ADDR_W-1:0]    req_reg_val,
    input  logic [ADDR_W-1:0]    req_disp,
    input  logic [ADDR_W-1:0]    req_pc,
    output logic                 acc_valid,
    output logic                 acc_illegal,
    output logic [ADDR_W-1:0]    acc_addr,
    output logic [1:0]           acc_lane,
    output logic                 wb_en,
    output logic [REG_NUM_W-1:0] wb_reg,
    output logic [ADDR_W-1:0]    wb_val
);
    logic [OFS_W-1:0]  ofs_q, ofs_use, ofs_next;
    logic [LEN_W-1:0]  len_bytes, step_bytes;
    logic              bad_len, illegal, wb_req;
    logic [ADDR_W-1:0] addr_c, wb_val_c;
    logic [1:0]        lane_c;

    // A new operand starts its parts from offset zero.
    always_comb ofs_use = req_new_op ? '0 : ofs_q;

    oau_len_decode #(.REG_NUM_W(REG_NUM_W), .SP_REG(SP_REG)) len_i (
        .len_code   (req_len_code),
        .reg_num    (req_reg_num),
        .len_bytes  (len_bytes),
        .step_bytes (step_bytes),
        .bad_len    (bad_len)
    );

    oau_legality #(.OFS_W(OFS_W)) legal_i (
        .flags     (req_flags),
        .is_store  (req_store),
        .len_bytes (len_bytes),
        .bad_len   (bad_len),
        .ofs_use   (ofs_use),
        .illegal   (illegal)
    );

    oau_addr_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PC_BIAS(PC_BIAS)) calc_i (
        .flags      (req_flags),
        .reg_val    (req_reg_val),
        .disp       (req_disp),
        .pc         (req_pc),
        .len_bytes  (len_bytes),
        .step_bytes (step_bytes),
        .ofs_use    (ofs_use),
        .addr       (addr_c),
        .lane       (lane_c),
        .wb_req     (wb_req),
        .wb_val     (wb_val_c),
        .ofs_next   (ofs_next)
    );

    // Register the result; an illegal access keeps the offset in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid   <= 1'b0;
            acc_illegal <= 1'b0;
            acc_addr    <= '0;
            acc_lane    <= '0;
            wb_en       <= 1'b0;
            wb_reg      <= '0;
            wb_val      <= '0;
            ofs_q       <= '0;
        end else begin
            acc_valid <= req_valid;
            wb_en     <= req_valid && wb_req && !illegal;
            if (req_valid) begin
                acc_illegal <= illegal;
                acc_addr    <= addr_c;
                acc_lane    <= lane_c;
                wb_reg      <= req_reg_num;
                wb_val      <= wb_val_c;
                ofs_q       <= illegal ? ofs_use : ofs_next;
            end
        end
    end
endmodule

// File: rtl/oau_access_unit_chk.sv
// Property checker for the operand access address update unit, bound to
// every instance of the top module.
module oau_access_unit_chk
    import oau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [6:0]        req_flags,
    input logic [2:0]        req_len_code,
    input logic [ADDR_W-1:0] req_reg_val,
    input logic              acc_valid,
    input logic              acc_illegal,
    input logic [1:0]        acc_lane,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_val
);
    a_r11_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid == $past(req_valid));

    a_r11_wb_only_legal: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (acc_valid && !acc_illegal));

    a_r7_store_target: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(req_store && (req_flags[F_IMMED] || req_flags[F_PCREL])))
        |-> acc_illegal);

    a_r8_flag_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(req_flags[F_POSTINC] &&
                            (req_flags[F_PCREL] || req_flags[F_PREDEC])))
        |-> acc_illegal);

    a_r9_wide_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(req_flags[F_DIRECT] && req_len_code >= 3'd3))
        |-> acc_illegal);

    a_r3_predec_moves_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && $past(req_flags[F_PREDEC])) |-> (wb_val != $past(req_reg_val)));

    a_r10_memory_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(!req_flags[F_DIRECT] && !req_flags[F_IMMED]))
        |-> (acc_lane == 2'd0));
endmodule

bind oau_access_unit oau_access_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_flags    (req_flags),
    .req_len_code (req_len_code),
    .req_reg_val  (req_reg_val),
    .acc_valid    (acc_valid),
    .acc_illegal  (acc_illegal),
    .acc_lane     (acc_lane),
    .wb_en        (wb_en),
    .wb_val       (wb_val)
);

// File: tb/oau_access_unit_tb_top.sv
// Bench: sweeps every flag combination, length code, direction and two
// base registers, comparing against an arithmetic model of the unit.
module oau_access_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_new_op = 1'b0, req_store = 1'b0;
    logic [6:0]  req_flags = '0;
    logic [3:0]  req_reg_num = '0;
    logic [2:0]  req_len_code = '0;
    logic [31:0] req_reg_val = '0, req_disp = '0, req_pc = '0;
    logic        acc_valid, acc_illegal, wb_en;
    logic [31:0] acc_addr, wb_val;
    logic [1:0]  acc_lane;
    logic [3:0]  wb_reg;

    int n_tests = 0;
    int n_fail  = 0;
    int m_ofs   = 0;

    always #10 clk = ~clk;

    oau_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_new_op(req_new_op),
        .req_store(req_store), .req_flags(req_flags), .req_reg_num(req_reg_num),
        .req_len_code(req_len_code), .req_reg_val(req_reg_val), .req_disp(req_disp),
        .req_pc(req_pc), .acc_valid(acc_valid), .acc_illegal(acc_illegal),
        .acc_addr(acc_addr), .acc_lane(acc_lane), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_val(wb_val)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one access, wait one cycle, compare against the model.
    task automatic access(input logic [6:0] f, input bit st, input bit nop,
                          input logic [3:0] rn, input logic [2:0] lc,
                          input logic [31:0] rv, input logic [31:0] dp,
                          input logic [31:0] pc);
        int len, step, ofs_u, lane_e;
        bit bad, dir, imm, abs_m, ind, ill, wbe;
        logic [31:0] addr_e, base, wbv;
        string itag, atag;
        len = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 4 : (lc == 3) ? 8 :
              (lc == 4) ? 12 : 0;
        bad   = (lc > 4);
        step  = (len == 1 && rn == 15) ? 2 : len;
        ofs_u = nop ? 0 : m_ofs;
        dir   = f[0];
        imm   = !f[0] && f[1];
        abs_m = !f[0] && !f[1] && f[2];
        ind   = !f[0] && !f[1] && !f[2];
        ill   = bad || (st && (f[1] || f[3])) || (f[4] && (f[3] || f[5])) ||
                (dir && (len > 4 || ofs_u != 0));
        itag  = bad ? "R1" : (dir && (len > 4 || ofs_u != 0)) ? "R9" :
                (st && (f[1] || f[3])) ? "R7" : (f[4] && (f[3] || f[5])) ? "R8" : "R12";
        base  = f[3] ? pc + 32'd4 : f[5] ? rv - step : rv;
        if (dir || imm)    addr_e = 32'd0;
        else if (abs_m)    addr_e = dp + ofs_u;
        else if (f[5])     addr_e = base + (f[6] ? dp : 32'd0);
        else               addr_e = base + (f[6] ? dp : 32'd0) + ofs_u;
        atag  = (ind && f[5]) ? "R3" : (ind && f[4]) ? "R4" : (ofs_u != 0) ? "R5" : "R6";
        lane_e = ((dir || imm) && len == 1) ? 3 : ((dir || imm) && len == 2) ? 2 : 0;
        wbe   = !ill && ind && !f[3] && (f[4] || f[5]);
        wbv   = f[5] ? rv - step : rv + step;
        req_valid = 1'b1; req_flags = f; req_store = st; req_new_op = nop;
        req_reg_num = rn; req_len_code = lc; req_reg_val = rv; req_disp = dp; req_pc = pc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(acc_valid === 1'b1, "R11 valid", {31'd0, acc_valid}, 32'd1);
        chk(acc_illegal === ill, itag, {31'd0, acc_illegal}, {31'd0, ill});
        chk(wb_en === wbe, "R11 wb_en", {31'd0, wb_en}, {31'd0, wbe});
        if (!ill) begin
            chk(acc_addr === addr_e, atag, acc_addr, addr_e);
            chk(acc_lane === 2'(lane_e), "R10", {30'd0, acc_lane}, lane_e);
        end
        if (wbe) begin
            chk(wb_val === wbv, (len == 1 && rn == 15) ? "R2" : (f[5] ? "R3" : "R4"),
                wb_val, wbv);
            chk(wb_reg === rn, "R11 wb_reg", {28'd0, wb_reg}, {28'd0, rn});
        end
        if (!ill) m_ofs = (ind && (f[4] || f[5])) ? 0 : ((ofs_u + len) & 255);
        else      m_ofs = ofs_u;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int it;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_valid === 1'b0 && wb_en === 1'b0, "R11 reset",
            {30'd0, acc_valid, wb_en}, 32'd0);
        // Running offset across parts of a 12-byte absolute operand.
        access(7'b0000100, 1'b0, 1'b1, 4'd2, 3'd2, 32'h0, 32'h0000_8000, 32'h0);
        access(7'b0000100, 1'b0, 1'b0, 4'd2, 3'd2, 32'h0, 32'h0000_8000, 32'h0);
        // R12: an illegal store to a literal must not move the offset.
        access(7'b0000010, 1'b1, 1'b0, 4'd2, 3'd2, 32'h0, 32'h0000_8000, 32'h0);
        access(7'b0000100, 1'b0, 1'b0, 4'd2, 3'd2, 32'h0, 32'h0000_8000, 32'h0);
        chk(acc_addr === 32'h0000_8008, "R12 offset kept", acc_addr, 32'h0000_8008);
        // R2: byte postincrement on register 15 versus register 3.
        access(7'b0010000, 1'b0, 1'b1, 4'd15, 3'd0, 32'h0000_1000, 32'h0, 32'h0);
        chk(wb_val === 32'h0000_1002, "R2 sp byte step", wb_val, 32'h0000_1002);
        access(7'b0010000, 1'b0, 1'b1, 4'd3, 3'd0, 32'h0000_1000, 32'h0, 32'h0);
        chk(wb_val === 32'h0000_1001, "R2 byte step", wb_val, 32'h0000_1001);
        // Exhaustive sweep of flags, length codes, direction and registers.
        it = 0;
        for (int f = 0; f < 128; f++)
            for (int lc = 0; lc < 8; lc++)
                for (int st = 0; st < 2; st++)
                    for (int r = 0; r < 2; r++) begin
                        access(7'(f), st[0], (it % 3) == 0, r ? 4'd15 : 4'd3, 3'(lc),
                               32'h1000_0000 + 32'(it * 16), 32'hFFFF_FF00 + 32'(it & 255),
                               32'h0000_4000 + 32'(it * 2));
                        it++;
                    end
        @(negedge clk);
        chk(acc_valid === 1'b0, "R11 one cycle", {31'd0, acc_valid}, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule